// File: doc/BRIEF.md
# Filtered Dual Interrupt Combiner

This block merges the active-low interrupt lines of two downstream bus segments into one active-low, open-drain interrupt request toward the host. Each raw line is asynchronous, so it first passes through a register synchronizer. It then passes through a pulse-rejection filter that needs the line to hold a new level for a set number of system-clock cycles before the filtered level may change. A line going active and a line going idle have separate hold limits, so a short dip toward active and a short gap back to idle are each rejected on their own scale.

The filtered levels drive two outputs. The first is a drive-low enable for the shared open-drain request pin, which the pad turns into a pulled-low line; when released, the line floats high. The second is a pair of active-high per-channel flags that the control-register read path samples. The block has no channel-select input, so a channel reports whether or not the bus switch has it connected. All times are counts of system-clock cycles set by parameters. At 250 MHz the defaults of 250 and 125 cycles reject pulses shorter than 1 µs (active) and 0.5 µs (idle). The worst-case response is then 252 cycles going active and 127 cycles going idle, well inside the 4 µs and 2 µs response limits.

Top module: `irq_merge_filter`

## Requirements
- R1: While reset is held, and on the first cycle after it, `irq_flags` is all zero and `irq_od_pull` is 0 (pin released), whatever the inputs.
- R2: `irq_od_pull` is 1 exactly when at least one channel's filtered level is active. The request is the AND of the two active-low lines, so it is low if either is low.
- R3: A low pulse on `irq_in_n[i]` that lasts fewer than LOW_REJ_CYC clock cycles never sets `irq_flags[i]`. A low level held for exactly LOW_REJ_CYC cycles does set it.
- R4: While a channel's flag is set, a high gap on its input that lasts fewer than HIGH_REJ_CYC cycles never clears the flag.
- R5: A low level that starts just after a clock edge and is then held sets `irq_flags[i]` on exactly the SYNC_STAGES+LOW_REJ_CYC-th rising edge that follows.
- R6: A high level that starts just after a clock edge and is then held, on a channel whose flag is set, clears `irq_flags[i]` on exactly the SYNC_STAGES+HIGH_REJ_CYC-th rising edge that follows.
- R7: `irq_flags` is active-high, with bit 0 for channel 0 and bit 1 for channel 1. The two channels are filtered independently, and either one reports with no selection input involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in_n | input | NUM_CH | Raw active-low interrupt lines, bit i from channel i, asynchronous |
| irq_od_pull | output | 1 | Drive-low enable for the open-drain request pin (1 = pull low) |
| irq_flags | output | NUM_CH | Filtered per-channel interrupt flags, active-high |

## Verification
The assertions assume that reset is low from time zero and that the raw lines hold a defined 0 or 1 on every clock edge. The lines may change at any cycle, but they are never X or Z. The bench changes the lines only half a cycle away from the sampling edge and keeps them at known values through reset. Its random phase holds each line for between 1 and twice the active limit, so pulses fall on both sides of each rejection threshold. The flag checks can therefore count edges exactly.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

  typedef enum logic {
    LVL_ACTIVE = 1'b0,
    LVL_IDLE   = 1'b1
  } irq_lvl_e;

  function automatic int unsigned larger_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned run_cnt_width(input int unsigned limit);
    return (limit <= 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/irqm_sync.sv
module irqm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/irqm_glitch_filter.sv
module irqm_glitch_filter
  import irqm_pkg::*;
#(
  parameter int unsigned LOW_CYC  = 250,
  parameter int unsigned HIGH_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl
);
  localparam int unsigned MAXC = larger_of(LOW_CYC, HIGH_CYC);
  localparam int unsigned CW   = run_cnt_width(MAXC);
  localparam logic [CW-1:0] LO_LAST = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HI_LAST = CW'(HIGH_CYC - 1);
  localparam logic [CW-1:0] MAX_LAST = CW'(MAXC - 1);

  logic [CW-1:0] run_cnt;
  logic [CW-1:0] last_needed;

  always_comb begin
    last_needed = (lvl == LVL_IDLE) ? LO_LAST : HI_LAST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl     <= LVL_IDLE;
      run_cnt <= '0;
    end else if (din != lvl) begin
      if (run_cnt >= last_needed) begin
        lvl     <= din;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end else begin
      run_cnt <= '0;
    end
  end

  // R5 R6: a change of the filtered level always takes the synchronized value
  p_flip_follows_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl) |-> (lvl == $past(din)));

  // R3 R4: agreement between input and level at an edge holds the level
  p_agree_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (din == lvl) |=> $stable(lvl));

  // R4: run counter never passes the longer limit
  p_cnt_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= MAX_LAST);
endmodule

// File: rtl/irq_merge_filter.sv
module irq_merge_filter
  import irqm_pkg::*;
#(
  parameter int unsigned NUM_CH       = 2,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned LOW_REJ_CYC  = 250,
  parameter int unsigned HIGH_REJ_CYC = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] irq_in_n,
  output logic              irq_od_pull,
  output logic [NUM_CH-1:0] irq_flags
);
  logic [NUM_CH-1:0] synced_n;
  logic [NUM_CH-1:0] filt_n;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    irqm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (irq_in_n[ch]),
      .q_sync  (synced_n[ch])
    );

    irqm_glitch_filter #(.LOW_CYC(LOW_REJ_CYC), .HIGH_CYC(HIGH_REJ_CYC)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (synced_n[ch]),
      .lvl   (filt_n[ch])
    );

    // R5: a flag only rises after the synchronizer presented an active level
    p_rise_from_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flags[ch]) |-> ($past(synced_n[ch]) == 1'b0));

    // R6: a flag only falls after the synchronizer presented an idle level
    p_fall_from_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_flags[ch]) |-> ($past(synced_n[ch]) == 1'b1));
  end

  assign irq_flags   = ~filt_n;
  assign irq_od_pull = ~(&filt_n);
endmodule

// File: tb/sim_irq_merge_filter.sv
module sim_irq_merge_filter;
  localparam int SYNC = 2;
  localparam int LO   = 20;
  localparam int HI   = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] irq_n;
  logic       pull;
  logic [1:0] flags;

  int n_run  = 0;
  int n_fail = 0;

  logic [1:0] m_s0, m_s1, m_lvl;
  int         m_run [2];

  always #2 clk = ~clk;

  irq_merge_filter #(.NUM_CH(2), .SYNC_STAGES(SYNC), .LOW_REJ_CYC(LO), .HIGH_REJ_CYC(HI)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in_n(irq_n), .irq_od_pull(pull), .irq_flags(flags)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int needed_run(input logic cur);
    return cur ? LO : HI;
  endfunction

  function automatic logic exp_pull(input logic [1:0] lv);
    return lv != 2'b11;
  endfunction

  // one clock: model update at the edge, comparison half a cycle later
  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      m_s0 = 2'b11; m_s1 = 2'b11; m_lvl = 2'b11; m_run[0] = 0; m_run[1] = 0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (m_s1[c] != m_lvl[c]) begin
          m_run[c]++;
          if (m_run[c] >= needed_run(m_lvl[c])) begin
            m_lvl[c] = m_s1[c];
            m_run[c] = 0;
          end
        end else m_run[c] = 0;
      end
      m_s1 = m_s0;
      m_s0 = irq_n;
    end
    @(negedge clk);
    chk(flags == ~m_lvl, "R7", "flags vs model", flags, ~m_lvl);
    chk(pull == exp_pull(m_lvl), "R2", "pull vs model", pull, exp_pull(m_lvl));
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int rem [2];
    void'($urandom(32'd7113));
    rst_n = 1'b0;
    irq_n = 2'b00;
    m_s0 = 2'b11; m_s1 = 2'b11; m_lvl = 2'b11; m_run[0] = 0; m_run[1] = 0;
    steps(4);
    chk(flags == 2'b00, "R1", "flags in reset", flags, 0);
    chk(pull == 1'b0, "R1", "pull in reset", pull, 0);
    irq_n = 2'b11;
    rst_n = 1'b1;
    step();
    chk(flags == 2'b00 && pull == 1'b0, "R1", "state after reset", {pull, flags}, 0);
    steps(3);

    // R3: one cycle short of the active limit is rejected
    irq_n[0] = 1'b0; steps(LO - 1);
    irq_n[0] = 1'b1; steps(LO + 5);
    chk(flags == 2'b00, "R3", "short low pulse", flags, 0);

    // R3 boundary: exactly the limit is accepted
    irq_n[1] = 1'b0; steps(LO);
    irq_n[1] = 1'b1; steps(SYNC);
    chk(flags[1] == 1'b1, "R3", "limit-wide low pulse", flags[1], 1);
    steps(SYNC + HI + 4);

    // R5: exact assertion latency
    irq_n[0] = 1'b0; steps(SYNC + LO - 1);
    chk(flags[0] == 1'b0, "R5", "flag before latency", flags[0], 0);
    step();
    chk(flags[0] == 1'b1, "R5", "flag at latency", flags[0], 1);
    chk(pull == 1'b1, "R2", "pull with ch0 active", pull, 1);

    // R4: short idle gap keeps the flag
    irq_n[0] = 1'b1; steps(HI - 1);
    irq_n[0] = 1'b0; steps(HI + 5);
    chk(flags[0] == 1'b1, "R4", "short high gap", flags[0], 1);

    // R6: exact release latency
    irq_n[0] = 1'b1; steps(SYNC + HI - 1);
    chk(flags[0] == 1'b1, "R6", "flag before release", flags[0], 1);
    step();
    chk(flags[0] == 1'b0, "R6", "flag at release", flags[0], 0);

    // R7: channel 1 alone, bit position
    irq_n[1] = 1'b0; steps(SYNC + LO + 1);
    chk(flags == 2'b10, "R7", "ch1 only", flags, 2);
    chk(pull == 1'b1, "R2", "pull with ch1 active", pull, 1);

    // R2: both, then release one, then the other
    irq_n[0] = 1'b0; steps(SYNC + LO + 1);
    chk(flags == 2'b11, "R7", "both active", flags, 3);
    irq_n[1] = 1'b1; steps(SYNC + HI + 1);
    chk(flags == 2'b01 && pull == 1'b1, "R2", "one still active", {pull, flags}, 3'b101);
    irq_n[0] = 1'b1; steps(SYNC + HI + 1);
    chk(pull == 1'b0, "R2", "all idle released", pull, 0);

    // random runs around both thresholds, checked against the model
    rem[0] = 1; rem[1] = 1;
    for (int k = 0; k < 4000; k++) begin
      for (int c = 0; c < 2; c++) begin
        rem[c]--;
        if (rem[c] == 0) begin
          irq_n[c] = ~irq_n[c];
          rem[c] = $urandom_range(1, 2 * LO);
        end
      end
      step();
    end

    // R1: reset in the middle of activity
    irq_n = 2'b00; steps(SYNC + LO + 2);
    rst_n = 1'b0; step();
    chk(flags == 2'b00 && pull == 1'b0, "R1", "reset mid-run", {pull, flags}, 0);
    rst_n = 1'b1; irq_n = 2'b11; steps(4);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule